// File: doc/BRIEF.md
# Paged Nonvolatile Register File Controller

This block sits behind a serial target interface and owns a small nonvolatile map. The map holds sixteen general-purpose bytes and three resistor-setting bytes. The front end hands it one byte write at a time, then a commit strobe when the bus transaction ends. Staged bytes collect in a two-byte page buffer. A commit starts a timed program cycle that rewrites the whole page. While the program cycle runs, a busy flag is held high, and the front end uses it to refuse its address.

The array is modelled as registers that reset to their factory contents. A write-time counter stands in for the program delay, and its length in clock cycles is a parameter. After reset, a one-cycle recall loads the resistor outputs from the array. Each resistor register drives a 6-bit position bus and a high-impedance enable. These outputs change only when a recall or a program cycle finishes.

Top module: `nvrf_ctrl`

## Requirements
- R1: While reset is asserted, `busy_o` is 1 and every `res_hiz_o` bit is 1. On the first clock edge after reset is released, the recall completes. From then on `busy_o` is 0, every resistor position reads 3Fh, and `res_hiz_o` is 0.
- R2: Address map. Byte addresses 00h–0Fh are user bytes, with a reset value of 00h. Addresses F8h, F9h and FAh hold resistor settings 0, 1 and 2, with a reset value of 3Fh. All other addresses are reserved and read as 00h. `rd_data_o` is a combinational read of the committed array at `rd_addr_i`.
- R3: A staged write to a reserved address is discarded. A commit after it starts no program cycle: `busy_o` stays 0.
- R4: A staged byte is not visible on `rd_data_o` or on the resistor outputs before its program cycle ends.
- R5: A commit that follows at least one accepted byte raises `busy_o` on the same clock edge. `busy_o` then stays high for exactly `WRITE_CYCLES` cycles.
- R6: Pages are address pairs starting at an even address. A single-byte write leaves the other byte of its page unchanged.
- R7: Two bytes written to both halves of one page before a single commit are both stored.
- R8: Once a page is open, a staged byte addressed to a different page is discarded.
- R9: While `busy_o` is 1, staged writes and commits are ignored. Reads return the contents from before the program cycle.
- R10: The position bus of resistor n is `res_pos_o[6n+5:6n]`. It takes the low six bits of the stored setting on the edge that ends the program cycle, and it holds its value at all other times.
- R11: A stored resistor setting above 3Fh sets that resistor's `res_hiz_o` bit. A setting from 00h to 3Fh clears it.
- R12: A commit with no accepted staged byte starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| wr_en_i | input | 1 | Stage one byte |
| wr_addr_i | input | 8 | Byte address of the staged write |
| wr_data_i | input | 8 | Staged byte |
| commit_i | input | 1 | End of transaction; starts the program cycle |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Committed byte at `rd_addr_i` |
| busy_o | output | 1 | Recall or program cycle in progress |
| res_pos_o | output | 18 | Three 6-bit resistor positions |
| res_hiz_o | output | 3 | Per-resistor high-impedance enable |

## Verification
The hardest situation to reach is traffic that lands inside the program window: writes and commits that arrive while `busy_o` is high. A correct front end never produces it. The stimulus deliberately starts a program cycle and, two cycles later, stages a byte to another page, commits it, and reads the page being programmed. It then confirms that the old contents were returned, that the late byte never reached the array, and that no second cycle followed. Every resistor value from 00h to FFh is also swept through the three registers, so that the boundary between valid and high-impedance settings is crossed on each lane.

// File: rtl/nvrf_pkg.sv
package nvrf_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/nvrf_addr_dec.sv
module nvrf_addr_dec #(
    parameter int          NUM_USER = 16,
    parameter int          NUM_RES  = 3,
    parameter logic [7:0]  RES_BASE = 8'hF8,
    parameter int          IDX_W    = 5
) (
    input  logic [7:0]       addr_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        if ({1'b0, addr_i} < 9'(NUM_USER)) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(addr_i);
        end else if (addr_i >= RES_BASE &&
                     {1'b0, addr_i} < (9'(RES_BASE) + 9'(NUM_RES))) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(NUM_USER) + IDX_W'(addr_i - RES_BASE);
        end
    end
endmodule

// File: rtl/nvrf_prog_timer.sv
module nvrf_prog_timer #(
    parameter int CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        done_o = tmr_q.busy && (tmr_q.cnt == '0);
        if (done_o) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);
    p_done_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/nvrf_pos_out.sv
module nvrf_pos_out
    import nvrf_pkg::*;
#(
    parameter int NUM_RES = 3,
    parameter int POS_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  byte_t [NUM_RES-1:0]      vals_i,
    output logic [NUM_RES*POS_W-1:0] pos_o,
    output logic [NUM_RES-1:0]       hiz_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             hiz;
    } lane_t;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_lane
        lane_t lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (load_i) begin
                lane_d.pos = vals_i[g][POS_W-1:0];
                lane_d.hiz = |vals_i[g][BYTE_W-1:POS_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '{pos: '0, hiz: 1'b1};
            else        lane_q <= lane_d;
        end

        assign pos_o[g*POS_W +: POS_W] = lane_q.pos;
        assign hiz_o[g]                = lane_q.hiz;

        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !load_i |=> ($stable(pos_o[g*POS_W +: POS_W]) && $stable(hiz_o[g])));
    end
endmodule

// File: rtl/nvrf_ctrl.sv
module nvrf_ctrl
    import nvrf_pkg::*;
#(
    parameter int         NUM_USER     = 16,
    parameter int         NUM_RES      = 3,
    parameter int         POS_W        = 6,
    parameter logic [7:0] RES_BASE     = 8'hF8,
    parameter logic [7:0] RES_DEFAULT  = 8'h3F,
    parameter int         WRITE_CYCLES = 2_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [7:0]               wr_addr_i,
    input  logic [7:0]               wr_data_i,
    input  logic                     commit_i,
    input  logic [7:0]               rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     busy_o,
    output logic [NUM_RES*POS_W-1:0] res_pos_o,
    output logic [NUM_RES-1:0]       res_hiz_o
);
    localparam int NUM_BYTES = NUM_USER + NUM_RES;
    localparam int IDX_W     = $clog2(NUM_BYTES + 1);
    localparam int PG_W      = IDX_W - 1;

    typedef struct packed {
        logic                      recall;
        logic                      open;
        logic [PG_W-1:0]           page;
        byte_t [1:0]               pbuf;
        byte_t [NUM_BYTES-1:0]     arr;
    } st_t;

    st_t st_d, st_q, st_rst;

    logic             wr_valid, rd_valid;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             tmr_start, tmr_busy, tmr_done;
    logic             out_load;
    logic             busy_all, stage_ok;
    byte_t [NUM_RES-1:0] out_vals;

    nvrf_addr_dec #(.NUM_USER(NUM_USER), .NUM_RES(NUM_RES),
                    .RES_BASE(RES_BASE), .IDX_W(IDX_W)) u_wr_dec (
        .addr_i (wr_addr_i),
        .valid_o(wr_valid),
        .idx_o  (wr_idx)
    );

    nvrf_addr_dec #(.NUM_USER(NUM_USER), .NUM_RES(NUM_RES),
                    .RES_BASE(RES_BASE), .IDX_W(IDX_W)) u_rd_dec (
        .addr_i (rd_addr_i),
        .valid_o(rd_valid),
        .idx_o  (rd_idx)
    );

    nvrf_prog_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(tmr_start),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    // Factory contents: user bytes clear, resistor settings at full scale.
    always_comb begin
        st_rst        = '0;
        st_rst.recall = 1'b1;
        for (int i = 0; i < NUM_BYTES; i++)
            st_rst.arr[i] = (i < NUM_USER) ? 8'h00 : RES_DEFAULT;
    end

    assign busy_all = tmr_busy | st_q.recall;
    assign stage_ok = wr_en_i && wr_valid && !busy_all;

    always_comb begin
        st_d      = st_q;
        tmr_start = 1'b0;
        out_load  = 1'b0;

        if (st_q.recall) begin
            st_d.recall = 1'b0;
            out_load    = 1'b1;
        end

        // Staging: first byte opens the page and preloads it from the array.
        if (stage_ok) begin
            if (!st_q.open) begin
                st_d.open    = 1'b1;
                st_d.page    = wr_idx[IDX_W-1:1];
                st_d.pbuf    = '0;
                for (int i = 0; i < NUM_BYTES; i++) begin
                    if (IDX_W'(i) == {wr_idx[IDX_W-1:1], 1'b0}) st_d.pbuf[0] = st_q.arr[i];
                    if (IDX_W'(i) == {wr_idx[IDX_W-1:1], 1'b1}) st_d.pbuf[1] = st_q.arr[i];
                end
                st_d.pbuf[wr_idx[0]] = wr_data_i;
            end else if (st_q.page == wr_idx[IDX_W-1:1]) begin
                st_d.pbuf[wr_idx[0]] = wr_data_i;
            end
        end

        if (commit_i && !busy_all && st_d.open)
            tmr_start = 1'b1;

        // End of program cycle: both bytes of the page are rewritten.
        if (tmr_done) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (IDX_W'(i) == {st_q.page, 1'b0}) st_d.arr[i] = st_q.pbuf[0];
                if (IDX_W'(i) == {st_q.page, 1'b1}) st_d.arr[i] = st_q.pbuf[1];
            end
            st_d.open = 1'b0;
            out_load  = 1'b1;
        end

        for (int r = 0; r < NUM_RES; r++)
            out_vals[r] = st_d.arr[NUM_USER + r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_valid)
            for (int i = 0; i < NUM_BYTES; i++)
                if (IDX_W'(i) == rd_idx) rd_data_o = st_q.arr[i];
    end

    assign busy_o = busy_all;

    nvrf_pos_out #(.NUM_RES(NUM_RES), .POS_W(POS_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(out_load),
        .vals_i(out_vals),
        .pos_o (res_pos_o),
        .hiz_o (res_hiz_o)
    );

    p_array_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_done |=> $stable(st_q.arr));
    p_reserved_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_valid && !st_q.open) |=> !st_q.open);
    p_busy_no_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |=> $stable(st_q.pbuf));
    p_recall_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.recall |=> !st_q.recall);
endmodule

// File: tb/nvrf_ctrl_bench.sv
`timescale 1ns/1ps
module nvrf_ctrl_bench;
    localparam int W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        commit = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [17:0] res_pos;
    logic [2:0]  res_hiz;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    nvrf_ctrl #(.WRITE_CYCLES(W)) u_nvrf_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .commit_i(commit), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .busy_o(busy), .res_pos_o(res_pos),
        .res_hiz_o(res_hiz)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [7:0] a, input string req);
        rd_addr = a;
        #1;
        check(rd_data == model[a], req, rd_data, model[a]);
    endtask

    task automatic stage(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 10 * W) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_outs(input string req);
        for (int r = 0; r < 3; r++) begin
            logic [7:0] v;
            v = model[8'hF8 + 8'(r)];
            check(res_pos[r*6 +: 6] == v[5:0], req, res_pos[r*6 +: 6], v[5:0]);
            check(res_hiz[r] == (v > 8'h3F), "R11", res_hiz[r], (v > 8'h3F));
        end
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog expired (R5 busy never cleared)");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < 256; a++)
            model[a] = (a < 16) ? 8'h00 : ((a >= 8'hF8 && a <= 8'hFA) ? 8'h3F : 8'h00);

        // R1: reset and recall
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R1", busy, 1);
        check(res_hiz == 3'b111, "R1", res_hiz, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", busy, 0);
        check_outs("R1");

        // R2: full read sweep of factory map
        for (int a = 0; a < 256; a++) read_chk(8'(a), "R2");

        // R4 R5 R6: single-byte writes across all user bytes
        for (int a = 0; a < 16; a++) begin
            logic [7:0] v;
            v = 8'((a * 29 + 7) & 8'hFF);
            stage(8'(a), v);
            read_chk(8'(a), "R4");
            do_commit();
            count_busy(n);
            check(n == W, "R5", n, W);
            model[a] = v;
            read_chk(8'(a), "R6");
            read_chk(8'(a ^ 1), "R6");
        end

        // R7: two-byte page write
        stage(8'h04, 8'hAA);
        stage(8'h05, 8'hBB);
        do_commit();
        count_busy(n);
        model[4] = 8'hAA; model[5] = 8'hBB;
        read_chk(8'h04, "R7");
        read_chk(8'h05, "R7");

        // R8: byte for another page is dropped
        stage(8'h06, 8'h11);
        stage(8'h09, 8'h22);
        do_commit();
        count_busy(n);
        model[6] = 8'h11;
        read_chk(8'h06, "R8");
        read_chk(8'h09, "R8");

        // R10 R11: every setting value through the three resistor registers
        for (int v = 0; v < 256; v++) begin
            logic [7:0] ra;
            ra = 8'hF8 + 8'(v % 3);
            stage(ra, 8'(v));
            check_outs("R4");
            do_commit();
            count_busy(n);
            model[ra] = 8'(v);
            check_outs("R10");
            read_chk(ra, "R2");
        end

        // R3: reserved addresses
        foreach (model[a]) begin
            if (a == 8'h10 || a == 8'hF7 || a == 8'hFB || a == 8'hFF) begin
                stage(8'(a), 8'h55);
                do_commit();
                check(busy == 1'b0, "R3", busy, 0);
                read_chk(8'(a), "R3");
            end
        end

        // R9: traffic during a program cycle
        stage(8'h02, 8'hCC);
        do_commit();
        @(negedge clk);
        read_chk(8'h02, "R9");
        stage(8'h0C, 8'hDD);
        do_commit();
        count_busy(n);
        model[2] = 8'hCC;
        read_chk(8'h02, "R9");
        read_chk(8'h0C, "R9");
        @(negedge clk);
        check(busy == 1'b0, "R9", busy, 0);

        // R12: commit with nothing staged
        do_commit();
        check(busy == 1'b0, "R12", busy, 0);
        @(negedge clk);
        check(busy == 1'b0, "R12", busy, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule